// File: doc/BRIEF.md
# Passive Matrix Display Scan Controller

This block runs one refresh of a bistable passive-matrix panel each time a host asks for it. For every row it fetches that row's pixel bits from a frame buffer read port. It clocks them one at a time into an external column shift chain. It then pulses the column latch, which moves the whole row to the column outputs at once. On the same edge it clocks the external row-select chain forward by one row, so the row selection and the column values change together.

After the last row has been held for its hold time, the block sends one more row clock with the row start line low. This shifts the selection out of the chain, so no row remains selected. The block then raises a one-cycle done pulse. It also toggles a polarity flag after every complete frame, so the analog stage can alternate the drive sign and keep the panel free of DC bias.

The column clock runs at the system clock divided by an even factor `DIV`. Each column clock period is one column slot. The frame buffer has one cycle of read latency. The analog levels and the high-voltage drivers are outside this block.

Top module: `pm_scan_ctrl`

## Requirements
- R1: A refresh starts only when `refresh_req` is high while the block is idle. After that, `busy` is high for exactly ROWS*((COLS+1)*DIV+HOLD)+DIV consecutive system clocks. Without a request, `busy` stays low.
- R2: Each row gets exactly COLS rising edges of `col_clk`. The bit presented at the c-th rising edge (c counted from 0) of row r is the frame buffer word at address r*COLS+c. `col_start` is high at the first of these edges and low at the others.
- R3: `col_data` holds the same value for at least one system clock before each rising edge of `col_clk`, and it does not change while `col_clk` is high.
- R4: `col_latch` pulses exactly once per row, after the row's last column clock edge and while `col_clk` is low. At that moment, the external chain (which shifts toward higher index, so column 0 ends at bit COLS-1) holds exactly that row's bits.
- R5: `row_clk` rises in the same cycle as every `col_latch` rise. `row_start` is high only at the first row clock of a frame. After k+1 row clocks, the external row chain is one-hot at bit k.
- R6: Consecutive row clock rising edges within a frame are exactly (COLS+1)*DIV+HOLD system clocks apart. This keeps each row selected for the row hold time before the next row's column shifting starts.
- R7: DIV+HOLD cycles after the last row's clock edge, one extra `row_clk` pulse with `row_start` low clears the row chain. `done` is then high for exactly one cycle, the cycle in which `busy` has just fallen.
- R8: `polarity` is 0 after reset, toggles in each cycle in which `done` is high, and holds its value at all other times.
- R9: A request that arrives while `busy` is high has no effect on the frame in progress and does not start another frame.
- R10: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_req | input | 1 | Start a frame refresh (accepted only when idle) |
| busy | output | 1 | Frame refresh in progress |
| done | output | 1 | One-cycle pulse at end of frame |
| polarity | output | 1 | Drive polarity flag, toggles per frame |
| row_start | output | 1 | Serial input to the row-select chain |
| row_clk | output | 1 | Row-select chain clock |
| col_start | output | 1 | Marks the first column bit of a row |
| col_clk | output | 1 | Column shift chain clock |
| col_data | output | 1 | Serial column bit |
| col_latch | output | 1 | Transfers the column chain to the column outputs |
| fb_addr | output | $clog2(ROWS*COLS) | Frame buffer read address |
| fb_rdata | input | 1 | Frame buffer pixel bit, one cycle after the address |

## Verification
The bench models the external column and row chains and follows every edge that the block produces. It sweeps solid, checkerboard and irregular pixel patterns over several frames. Its main targets are the following errors:
- A bit order or row/column address error. This would put the wrong word in the chain when the latch fires.
- An off-by-one on the frame buffer latency. This would shift each row by one column.
- Data that changes too close to a column clock edge.
- A latch that fires apart from the row clock. This would drive the old row with new data.
- A missing clearing pulse. This would leave the last row selected.
- A polarity flag that toggles per row instead of per frame.

Requests sent in the middle of a frame check that a block which restarts or stretches its frame is caught, through the busy length and the edge counts.

// File: rtl/pm_scan_pkg.sv
package pm_scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_STEP,
        ST_HOLD,
        ST_CLEAR,
        ST_FIN
    } scan_st_e;

    typedef struct packed {
        logic busy;
        logic done;
        logic pol;
        logic row_start;
        logic row_clk;
        logic col_start;
        logic col_clk;
        logic col_data;
        logic col_latch;
    } scan_drv_t;

    localparam scan_drv_t DRV_RESET = '0;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pm_scan_seq.sv
module pm_scan_seq
    import pm_scan_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int DIV  = 4,
    parameter int HOLD = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int TW = $clog2(max2(DIV, HOLD) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    output scan_st_e      st,
    output logic [TW-1:0] tick,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row
);

    localparam logic [TW-1:0] TICK_SLOT = TW'(DIV - 1);
    localparam logic [TW-1:0] TICK_HOLD = TW'(HOLD - 1);
    localparam logic [CW-1:0] COL_LAST  = CW'(COLS - 1);
    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            tick <= '0;
            col  <= '0;
            row  <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    tick <= '0;
                    col  <= '0;
                    row  <= '0;
                    if (req) st <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick == TICK_SLOT) begin
                        tick <= '0;
                        if (col == COL_LAST) begin
                            col <= '0;
                            st  <= ST_STEP;
                        end else begin
                            col <= col + 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_STEP: begin
                    if (tick == TICK_SLOT) begin
                        tick <= '0;
                        st   <= ST_HOLD;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tick == TICK_HOLD) begin
                        tick <= '0;
                        if (row == ROW_LAST) begin
                            st <= ST_CLEAR;
                        end else begin
                            row <= row + 1'b1;
                            st  <= ST_SHIFT;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                ST_CLEAR: begin
                    if (tick == TICK_SLOT) begin
                        tick <= '0;
                        st   <= ST_FIN;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pm_scan_addr.sv
module pm_scan_addr #(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int AW = $clog2(ROWS * COLS)
) (
    input  logic [RW-1:0] row,
    input  logic [CW-1:0] col,
    output logic [AW-1:0] addr
);

    localparam bit COLS_POW2 = ((COLS & (COLS - 1)) == 0);

    generate
        if (COLS_POW2) begin : g_concat
            assign addr = AW'({row, col});
        end else begin : g_mult
            assign addr = AW'(int'(row) * COLS + int'(col));
        end
    endgenerate

endmodule

// File: rtl/pm_scan_drive.sv
module pm_scan_drive
    import pm_scan_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int DIV  = 4,
    parameter int HOLD = 8,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(COLS),
    localparam int TW = $clog2(max2(DIV, HOLD) + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  scan_st_e      st,
    input  logic [TW-1:0] tick,
    input  logic [CW-1:0] col,
    input  logic [RW-1:0] row,
    input  logic          fb_rdata,
    output scan_drv_t     q
);

    localparam int HALF = DIV / 2;
    localparam logic [TW-1:0] T_HALF = TW'(HALF);
    localparam logic [TW-1:0] T_ONE  = TW'(1);

    scan_drv_t d;
    logic      pulse;

    assign pulse = (tick >= T_ONE) && (tick <= T_HALF);

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.row_start = 1'b0;
        d.row_clk   = 1'b0;
        d.col_start = 1'b0;
        d.col_clk   = 1'b0;
        d.col_latch = 1'b0;
        d.busy      = (st == ST_SHIFT) || (st == ST_STEP) ||
                      (st == ST_HOLD)  || (st == ST_CLEAR);
        case (st)
            ST_SHIFT: begin
                d.col_clk   = (tick >= T_HALF);
                d.col_start = (col == '0);
                if (tick == T_ONE) d.col_data = fb_rdata;
            end
            ST_STEP: begin
                d.row_start = (row == '0);
                d.row_clk   = pulse;
                d.col_latch = pulse;
            end
            ST_CLEAR: begin
                d.row_clk = pulse;
            end
            ST_FIN: begin
                d.done = 1'b1;
                d.pol  = ~q.pol;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= DRV_RESET;
        else     q <= d;
    end

endmodule

// File: rtl/pm_scan_ctrl.sv
module pm_scan_ctrl
    import pm_scan_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 32,
    parameter int DIV  = 4,
    parameter int HOLD = 8,
    localparam int AW = $clog2(ROWS * COLS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          refresh_req,
    output logic          busy,
    output logic          done,
    output logic          polarity,
    output logic          row_start,
    output logic          row_clk,
    output logic          col_start,
    output logic          col_clk,
    output logic          col_data,
    output logic          col_latch,
    output logic [AW-1:0] fb_addr,
    input  logic          fb_rdata
);

    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int TW = $clog2(max2(DIV, HOLD) + 1);

    scan_st_e      st;
    logic [TW-1:0] tick;
    logic [CW-1:0] col;
    logic [RW-1:0] row;
    scan_drv_t     drv;

    pm_scan_seq #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .HOLD(HOLD)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .req  (refresh_req),
        .st   (st),
        .tick (tick),
        .col  (col),
        .row  (row)
    );

    pm_scan_addr #(.ROWS(ROWS), .COLS(COLS)) u_addr (
        .row  (row),
        .col  (col),
        .addr (fb_addr)
    );

    pm_scan_drive #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .HOLD(HOLD)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .tick     (tick),
        .col      (col),
        .row      (row),
        .fb_rdata (fb_rdata),
        .q        (drv)
    );

    assign busy      = drv.busy;
    assign done      = drv.done;
    assign polarity  = drv.pol;
    assign row_start = drv.row_start;
    assign row_clk   = drv.row_clk;
    assign col_start = drv.col_start;
    assign col_clk   = drv.col_clk;
    assign col_data  = drv.col_data;
    assign col_latch = drv.col_latch;

endmodule

// File: rtl/pm_scan_chk.sv
module pm_scan_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic polarity,
    input logic row_start,
    input logic row_clk,
    input logic col_clk,
    input logic col_data,
    input logic col_latch
);

    p_data_stable_r3: assert property (@(posedge clk) disable iff (rst)
        col_clk |-> $stable(col_data));

    p_latch_clk_low_r4: assert property (@(posedge clk) disable iff (rst)
        col_latch |-> !col_clk);

    p_latch_rowclk_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(col_latch) |-> $rose(row_clk));

    p_start_busy_r5: assert property (@(posedge clk) disable iff (rst)
        row_start |-> busy);

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_pol_flip_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (polarity != $past(polarity)));

    p_pol_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(polarity));

endmodule

bind pm_scan_ctrl pm_scan_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .polarity  (polarity),
    .row_start (row_start),
    .row_clk   (row_clk),
    .col_clk   (col_clk),
    .col_data  (col_data),
    .col_latch (col_latch)
);

// File: tb/tb_pm_scan_ctrl.sv
module tb_pm_scan_ctrl;

    localparam int ROWS     = 4;
    localparam int COLS     = 8;
    localparam int DIV      = 4;
    localparam int HOLD     = 3;
    localparam int AW       = $clog2(ROWS * COLS);
    localparam int ROW_PER  = (COLS + 1) * DIV + HOLD;
    localparam int BUSY_LEN = ROWS * ROW_PER + DIV;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic refresh_req = 1'b0;
    logic busy, done, polarity, row_start, row_clk;
    logic col_start, col_clk, col_data, col_latch;
    logic [AW-1:0] fb_addr;
    logic fb_rdata = 1'b0;

    always #10 clk = ~clk;

    pm_scan_ctrl #(.ROWS(ROWS), .COLS(COLS), .DIV(DIV), .HOLD(HOLD)) dut (
        .clk(clk), .rst(rst), .refresh_req(refresh_req),
        .busy(busy), .done(done), .polarity(polarity),
        .row_start(row_start), .row_clk(row_clk),
        .col_start(col_start), .col_clk(col_clk), .col_data(col_data),
        .col_latch(col_latch), .fb_addr(fb_addr), .fb_rdata(fb_rdata)
    );

    int n_chk = 0;
    int n_bad = 0;
    int pat = 0;

    function automatic logic pix(input int p, input int r, input int c);
        case (p)
            0: return 1'b0;
            1: return 1'b1;
            2: return 1'((r ^ c) & 1);
            3: return (((r * 5 + c * 3 + (c >> 2)) % 7) < 3);
            default: return 1'(((r + 1) * (c + 2) >> 1) & 1);
        endcase
    endfunction

    always @(posedge clk)
        fb_rdata <= pix(pat, int'(fb_addr) / COLS, int'(fb_addr) % COLS);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // models of the external chains and event counters
    logic            mon_en = 1'b0;
    int              cyc = 0, busy_cnt = 0, latch_cnt = 0, rclk_cnt = 0;
    int              crise_cnt = 0, bitcnt = 0, done_cnt = 0, last_rise = 0;
    logic [COLS-1:0] sh = '0;
    logic [ROWS-1:0] chain = '0;
    logic            p_cclk = 0, p_rclk = 0, p_latch = 0, p_data = 0, p_busy = 0;

    always @(negedge clk) begin
        cyc++;
        if (mon_en) begin
            if (busy) busy_cnt++;
            if (col_clk && !p_cclk) begin
                chk(col_data == p_data, "R3 setup", int'(col_data), int'(p_data));
                chk(col_start == (bitcnt == 0), "R2 col_start", int'(col_start), int'(bitcnt == 0));
                chk(col_data == pix(pat, latch_cnt, bitcnt), "R2 bit value",
                    int'(col_data), int'(pix(pat, latch_cnt, bitcnt)));
                sh = {sh[COLS-2:0], col_data};
                bitcnt++;
                crise_cnt++;
            end
            if (col_clk && p_cclk)
                chk(col_data == p_data, "R3 hold", int'(col_data), int'(p_data));
            if (col_latch && !p_latch) begin
                logic [COLS-1:0] exp_w;
                for (int c = 0; c < COLS; c++) exp_w[COLS-1-c] = pix(pat, latch_cnt, c);
                chk(bitcnt == COLS, "R4 bits before latch", bitcnt, COLS);
                chk(sh == exp_w, "R4 latched word", int'(sh), int'(exp_w));
                chk(row_clk && !p_rclk, "R5 latch with row clock", int'(row_clk), 1);
                bitcnt = 0;
                latch_cnt++;
            end
            if (row_clk && !p_rclk) begin
                chk(row_start == (rclk_cnt == 0), "R5 row_start", int'(row_start), int'(rclk_cnt == 0));
                chain = {chain[ROWS-2:0], row_start};
                if (rclk_cnt < ROWS) begin
                    chk(chain == ROWS'(1) << rclk_cnt, "R5 one-hot row", int'(chain), 1 << rclk_cnt);
                    if (rclk_cnt > 0)
                        chk(cyc - last_rise == ROW_PER, "R6 row period", cyc - last_rise, ROW_PER);
                end else begin
                    chk(chain == '0, "R7 chain cleared", int'(chain), 0);
                    chk(cyc - last_rise == DIV + HOLD, "R7 clear delay", cyc - last_rise, DIV + HOLD);
                end
                last_rise = cyc;
                rclk_cnt++;
            end
            if (done) begin
                done_cnt++;
                chk(p_busy && !busy, "R7 done as busy falls", int'(busy), 0);
            end
        end
        p_cclk  = col_clk;
        p_rclk  = row_clk;
        p_latch = col_latch;
        p_data  = col_data;
        p_busy  = busy;
    end

    int frames = 0;

    task automatic run_frame(input int p, input bit mid);
        int w;
        pat = p;
        busy_cnt = 0; latch_cnt = 0; rclk_cnt = 0; crise_cnt = 0;
        bitcnt = 0; done_cnt = 0;
        @(negedge clk) refresh_req = 1'b1;
        @(negedge clk) refresh_req = 1'b0;
        w = 0;
        while (done_cnt == 0 && w < BUSY_LEN + 50) begin
            @(negedge clk);
            w++;
            refresh_req = mid && (w == 40 || w == 90);
        end
        refresh_req = 1'b0;
        repeat (3) @(negedge clk);
        frames++;
        chk(busy_cnt == BUSY_LEN, "R1 busy length", busy_cnt, BUSY_LEN);
        chk(crise_cnt == ROWS * COLS, "R2 column clocks", crise_cnt, ROWS * COLS);
        chk(latch_cnt == ROWS, "R4 latch count", latch_cnt, ROWS);
        chk(rclk_cnt == ROWS + 1, "R7 row clock count", rclk_cnt, ROWS + 1);
        chk(done_cnt == 1, "R7 done width", done_cnt, 1);
        chk(chain == '0, "R7 no row selected", int'(chain), 0);
        chk(polarity == 1'(frames % 2), "R8 polarity", int'(polarity), frames % 2);
        if (mid) begin
            repeat (20) @(negedge clk);
            chk(!busy && busy_cnt == BUSY_LEN, "R9 mid-frame request ignored", busy_cnt, BUSY_LEN);
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({busy, done, polarity, row_start, row_clk, col_start, col_clk, col_data, col_latch} == '0,
            "R10 reset outputs", int'(busy), 0);
        mon_en = 1'b1;
        repeat (10) @(negedge clk);
        chk(!busy && busy_cnt == 0, "R1 idle without request", busy_cnt, 0);
        run_frame(0, 1'b0);
        run_frame(1, 1'b0);
        run_frame(2, 1'b1);
        run_frame(3, 1'b0);
        run_frame(4, 1'b1);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule